// File: doc/BRIEF.md
# Host Schedule Single-Step Controller

This block sequences the walk of a USB host schedule. Starting from a frame's first descriptor, it follows descriptor links one at a time and asks an external fetch port for each descriptor's active flag, next link and terminate marker. For every active descriptor it fires a one-cycle execute strobe and waits for a done pulse from the execution engine. A terminate marker ends the frame, and the walk of the next frame begins on the next frame-start tick.

Software controls the block through a run bit and a debug-enable bit, both written together. In normal mode the schedule runs continuously until software clears run. The block then halts once the transaction in progress has finished and clears its frame counter, so a later start goes back to the frame index that software supplies. In debug mode the block runs exactly one active descriptor at a time. It clears its own run bit as soon as it finds an active descriptor. It sets halted when that descriptor completes. When that descriptor ended its frame, the block first waits for the next frame start and fetches that frame's head descriptor, and only then sets halted.

Top module: `sched_step_ctrl`

## Requirements
- R1: After reset, halted is 1, run and debug bits are 0, the frame number is 0, and neither fetch_req nor exec_stb is asserted while halted.
- R2: A software write with cfg_run=1 while halted drops halted at the clock edge that takes the write.
- R3: When a software write with cfg_run=1 lands in the same cycle that debug mode would clear run, run stays 1 and the found descriptor still executes.
- R4: A start from halt in normal mode loads the frame number from frame_index, and the first fetch uses frame_head of that frame.
- R5: Descriptors with active=0 are passed over by following their link. A descriptor with the terminate marker ends the frame. Each frame-start tick then adds one to the frame number and restarts at that frame's head. A frame with no active descriptor executes nothing.
- R6: exec_stb is high for exactly one cycle per active descriptor, and no fetch is issued until exec_done arrives.
- R7: In debug mode, the run bit reads 0 in the same cycle that exec_stb fires for the found descriptor.
- R8: In debug mode, halted is set when exec_done arrives for a descriptor with no terminate marker, and td_ptr then holds its link. A new run write resumes there and passes over inactive descriptors before executing the next active one.
- R9: In debug mode, after a terminate-marked descriptor is executed, halted stays 0 until a frame-start tick. The block then fetches the new frame's head and halts with td_ptr on it and the frame number advanced, without executing it.
- R10: In normal mode, clearing run during an execution leaves halted at 0 until exec_done. The block then halts with the frame number at 0.
- R11: A write with cfg_dbg=0 and cfg_run=1 after a debug halt restarts from frame_index and runs frames continuously without halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Software write strobe for the run and debug bits |
| cfg_run | input | 1 | Run value written |
| cfg_dbg | input | 1 | Debug-enable value written |
| sof_tick | input | 1 | Frame-start pulse |
| frame_index | input | FRM_W | Frame number loaded on a fresh start |
| frame_head | input | PTR_W | First descriptor of the frame given by frame_num |
| fetch_req | output | 1 | Fetch request for the descriptor at td_ptr |
| fetch_vld | input | 1 | Fetch response valid |
| fetch_active | input | 1 | Active flag of the fetched descriptor |
| fetch_term | input | 1 | Terminate marker of the fetched descriptor's link |
| fetch_link | input | PTR_W | Next descriptor pointer |
| exec_stb | output | 1 | One-cycle start for the execution engine |
| exec_done | input | 1 | Execution complete pulse |
| td_ptr | output | PTR_W | Current descriptor pointer |
| frame_num | output | FRM_W | Current frame number |
| run_bit | output | 1 | Run bit, including hardware clears |
| dbg_bit | output | 1 | Debug-enable bit |
| halted | output | 1 | Halted status |

## Verification
Two things can hit the run bit in the same cycle: a software write and the clear that debug mode issues when the fetch returns an active descriptor. The bench first makes the controller resume at an inactive descriptor. It counts cycles so that a second run write lands exactly on the cycle the next, active descriptor is returned. The outcome is judged at the ports: run must still read 1, and the strobe must still fire for that descriptor.

// File: rtl/sched_step_pkg.sv
`timescale 1ns/1ps
package sched_step_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_START,
        ST_FETCH,
        ST_EXEC,
        ST_WSOF
    } walk_st_e;

    typedef struct packed {
        logic run;
        logic dbg;
        logic halted;
    } cmd_t;

endpackage

// File: rtl/sched_cmd_reg.sv
`timescale 1ns/1ps
module sched_cmd_reg
    import sched_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_run,
    input  logic cfg_dbg,
    input  logic hw_clr_run,
    input  logic halt_set,
    output logic run_bit,
    output logic dbg_bit,
    output logic halted
);

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        // software write has priority over the hardware clear
        if (cfg_wr) begin
            cmd_d.run = cfg_run;
            cmd_d.dbg = cfg_dbg;
        end else if (hw_clr_run) begin
            cmd_d.run = 1'b0;
        end
        if (cfg_wr && cfg_run) begin
            cmd_d.halted = 1'b0;
        end else if (halt_set) begin
            cmd_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{run: 1'b0, dbg: 1'b0, halted: 1'b1};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign run_bit = cmd_q.run;
    assign dbg_bit = cmd_q.dbg;
    assign halted  = cmd_q.halted;

endmodule

// File: rtl/sched_frame_ctr.sv
`timescale 1ns/1ps
module sched_frame_ctr #(
    parameter int FRM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_clr,
    input  logic             frm_load,
    input  logic             frm_inc,
    input  logic [FRM_W-1:0] load_val,
    output logic [FRM_W-1:0] frm_cnt
);

    localparam logic [FRM_W-1:0] FRM_ONE = {{(FRM_W-1){1'b0}}, 1'b1};

    logic [FRM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (frm_clr) begin
            cnt_d = '0;
        end else if (frm_load) begin
            cnt_d = load_val;
        end else if (frm_inc) begin
            cnt_d = cnt_q + FRM_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign frm_cnt = cnt_q;

endmodule

// File: rtl/sched_walk_fsm.sv
`timescale 1ns/1ps
module sched_walk_fsm
    import sched_step_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_run,
    input  logic             cfg_dbg,
    input  logic             run_bit,
    input  logic             dbg_bit,
    input  logic             sof_tick,
    input  logic [PTR_W-1:0] frame_head,
    input  logic             fetch_vld,
    input  logic             fetch_active,
    input  logic             fetch_term,
    input  logic [PTR_W-1:0] fetch_link,
    input  logic             exec_done,
    output logic             fetch_req,
    output logic [PTR_W-1:0] td_ptr,
    output logic             exec_stb,
    output logic             hw_clr_run,
    output logic             halt_set,
    output logic             frm_load,
    output logic             frm_inc,
    output logic             frm_clr
);

    typedef struct packed {
        walk_st_e         st;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] nlink;
        logic             last;
        logic             step;
        logic             pfh;
        logic             resume;
        logic             stb;
    } walk_t;

    walk_t w_d, w_q;
    logic  sw_go;
    logic  run_eff;

    assign sw_go   = cfg_wr && cfg_run;
    assign run_eff = run_bit || sw_go;

    always_comb begin
        w_d        = w_q;
        w_d.stb    = 1'b0;
        hw_clr_run = 1'b0;
        halt_set   = 1'b0;
        frm_load   = 1'b0;
        frm_inc    = 1'b0;
        frm_clr    = 1'b0;
        unique case (w_q.st)
            ST_HALT: begin
                if (sw_go) begin
                    w_d.resume = 1'b0;
                    if (w_q.resume && cfg_dbg) begin
                        w_d.st = ST_FETCH;
                    end else begin
                        frm_load = 1'b1;
                        w_d.st   = ST_START;
                    end
                end
            end
            ST_START: begin
                w_d.ptr = frame_head;
                w_d.st  = ST_FETCH;
            end
            ST_FETCH: begin
                if (fetch_vld) begin
                    if (w_q.pfh) begin
                        // prefetch after the last step of a frame
                        w_d.pfh = 1'b0;
                        if (!sw_go) begin
                            halt_set   = 1'b1;
                            w_d.resume = 1'b1;
                            w_d.st     = ST_HALT;
                        end
                    end else if (!run_eff) begin
                        halt_set   = 1'b1;
                        frm_clr    = 1'b1;
                        w_d.resume = 1'b0;
                        w_d.st     = ST_HALT;
                    end else if (fetch_active) begin
                        w_d.stb    = 1'b1;
                        w_d.st     = ST_EXEC;
                        w_d.nlink  = fetch_link;
                        w_d.last   = fetch_term;
                        w_d.step   = dbg_bit && !sw_go;
                        hw_clr_run = dbg_bit && !sw_go;
                    end else if (fetch_term) begin
                        w_d.st = ST_WSOF;
                    end else begin
                        w_d.ptr = fetch_link;
                    end
                end
            end
            ST_EXEC: begin
                if (exec_done) begin
                    w_d.step = 1'b0;
                    if (w_q.step && !sw_go) begin
                        if (w_q.last) begin
                            w_d.pfh = 1'b1;
                            w_d.st  = ST_WSOF;
                        end else begin
                            w_d.ptr    = w_q.nlink;
                            halt_set   = 1'b1;
                            w_d.resume = 1'b1;
                            w_d.st     = ST_HALT;
                        end
                    end else if (!run_eff) begin
                        halt_set   = 1'b1;
                        frm_clr    = 1'b1;
                        w_d.resume = 1'b0;
                        w_d.st     = ST_HALT;
                    end else if (w_q.last) begin
                        w_d.st = ST_WSOF;
                    end else begin
                        w_d.ptr = w_q.nlink;
                        w_d.st  = ST_FETCH;
                    end
                end
            end
            ST_WSOF: begin
                if (!w_q.pfh && !run_eff) begin
                    halt_set   = 1'b1;
                    frm_clr    = 1'b1;
                    w_d.resume = 1'b0;
                    w_d.st     = ST_HALT;
                end else if (sof_tick) begin
                    frm_inc = 1'b1;
                    w_d.st  = ST_START;
                end
            end
            default: begin
                w_d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: ST_HALT, ptr: '0, nlink: '0, last: 1'b0, step: 1'b0,
                     pfh: 1'b0, resume: 1'b0, stb: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign fetch_req = (w_q.st == ST_FETCH);
    assign td_ptr    = w_q.ptr;
    assign exec_stb  = w_q.stb;

endmodule

// File: rtl/sched_step_ctrl.sv
`timescale 1ns/1ps
module sched_step_ctrl #(
    parameter int PTR_W = 16,
    parameter int FRM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_run,
    input  logic             cfg_dbg,
    input  logic             sof_tick,
    input  logic [FRM_W-1:0] frame_index,
    input  logic [PTR_W-1:0] frame_head,
    output logic             fetch_req,
    input  logic             fetch_vld,
    input  logic             fetch_active,
    input  logic             fetch_term,
    input  logic [PTR_W-1:0] fetch_link,
    output logic             exec_stb,
    input  logic             exec_done,
    output logic [PTR_W-1:0] td_ptr,
    output logic [FRM_W-1:0] frame_num,
    output logic             run_bit,
    output logic             dbg_bit,
    output logic             halted
);

    logic hw_clr_run;
    logic halt_set;
    logic frm_load;
    logic frm_inc;
    logic frm_clr;

    sched_cmd_reg i_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_run    (cfg_run),
        .cfg_dbg    (cfg_dbg),
        .hw_clr_run (hw_clr_run),
        .halt_set   (halt_set),
        .run_bit    (run_bit),
        .dbg_bit    (dbg_bit),
        .halted     (halted)
    );

    sched_frame_ctr #(.FRM_W(FRM_W)) i_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_clr  (frm_clr),
        .frm_load (frm_load),
        .frm_inc  (frm_inc),
        .load_val (frame_index),
        .frm_cnt  (frame_num)
    );

    sched_walk_fsm #(.PTR_W(PTR_W)) i_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_run      (cfg_run),
        .cfg_dbg      (cfg_dbg),
        .run_bit      (run_bit),
        .dbg_bit      (dbg_bit),
        .sof_tick     (sof_tick),
        .frame_head   (frame_head),
        .fetch_vld    (fetch_vld),
        .fetch_active (fetch_active),
        .fetch_term   (fetch_term),
        .fetch_link   (fetch_link),
        .exec_done    (exec_done),
        .fetch_req    (fetch_req),
        .td_ptr       (td_ptr),
        .exec_stb     (exec_stb),
        .hw_clr_run   (hw_clr_run),
        .halt_set     (halt_set),
        .frm_load     (frm_load),
        .frm_inc      (frm_inc),
        .frm_clr      (frm_clr)
    );

endmodule

// File: rtl/sched_step_chk.sv
`timescale 1ns/1ps
module sched_step_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_run,
    input logic fetch_req,
    input logic fetch_vld,
    input logic fetch_active,
    input logic exec_stb,
    input logic run_bit,
    input logic dbg_bit,
    input logic halted
);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb); // R6

    AST_NO_FETCH_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |-> !fetch_req); // R6

    AST_HALT_DROPS_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && cfg_wr && cfg_run) |=> !halted); // R2

    AST_SW_RUN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_run) |=> run_bit); // R3

    AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!fetch_req && !exec_stb)); // R1

    AST_DBG_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_bit && fetch_req && fetch_vld && fetch_active && !cfg_wr) |=> !run_bit); // R7

endmodule

bind sched_step_ctrl sched_step_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_run      (cfg_run),
    .fetch_req    (fetch_req),
    .fetch_vld    (fetch_vld),
    .fetch_active (fetch_active),
    .exec_stb     (exec_stb),
    .run_bit      (run_bit),
    .dbg_bit      (dbg_bit),
    .halted       (halted)
);

// File: tb/test_sched_step_ctrl.sv
`timescale 1ns/1ps
module test_sched_step_ctrl;

    localparam int PTR_W = 16;
    localparam int FRM_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_run = 1'b0;
    logic             cfg_dbg = 1'b0;
    logic             sof_tick = 1'b0;
    logic [FRM_W-1:0] frame_index = '0;
    logic [PTR_W-1:0] frame_head;
    logic             fetch_req;
    logic             fetch_vld = 1'b0;
    logic             fetch_active = 1'b0;
    logic             fetch_term = 1'b0;
    logic [PTR_W-1:0] fetch_link = '0;
    logic             exec_stb;
    logic             exec_done = 1'b0;
    logic [PTR_W-1:0] td_ptr;
    logic [FRM_W-1:0] frame_num;
    logic             run_bit;
    logic             dbg_bit;
    logic             halted;

    int checks = 0;
    int fails  = 0;
    int n_exec = 0;
    int lat    = 3;
    int exec_log [0:63];
    bit stb_double = 1'b0;
    bit sof_en = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sched_step_ctrl #(.PTR_W(PTR_W), .FRM_W(FRM_W)) i_sched_step_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_dbg(cfg_dbg),
        .sof_tick(sof_tick), .frame_index(frame_index), .frame_head(frame_head),
        .fetch_req(fetch_req), .fetch_vld(fetch_vld), .fetch_active(fetch_active),
        .fetch_term(fetch_term), .fetch_link(fetch_link), .exec_stb(exec_stb),
        .exec_done(exec_done), .td_ptr(td_ptr), .frame_num(frame_num),
        .run_bit(run_bit), .dbg_bit(dbg_bit), .halted(halted)
    );

    // frame list: frame 5 -> 8, frame 6 -> 10, all others -> 1
    assign frame_head = (frame_num == 5) ? 16'd8 : (frame_num == 6) ? 16'd10 : 16'd1;

    // descriptors: 1 act->4, 4 inactive->5, 5 act term, 8 act term, 10 inactive term
    function automatic bit td_act(input logic [PTR_W-1:0] p);
        return (p == 1) || (p == 5) || (p == 8);
    endfunction
    function automatic bit td_term(input logic [PTR_W-1:0] p);
        return !((p == 1) || (p == 4));
    endfunction
    function automatic logic [PTR_W-1:0] td_link(input logic [PTR_W-1:0] p);
        return (p == 1) ? 16'd4 : (p == 4) ? 16'd5 : 16'd0;
    endfunction

    // fetch and execution responders
    initial begin
        int cnt;
        bit busy;
        bit prev_stb;
        cnt = 0; busy = 1'b0; prev_stb = 1'b0;
        forever begin
            @(negedge clk);
            fetch_vld    = fetch_req;
            fetch_active = td_act(td_ptr);
            fetch_term   = td_term(td_ptr);
            fetch_link   = td_link(td_ptr);
            exec_done    = 1'b0;
            if (busy) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    exec_done = 1'b1;
                    busy = 1'b0;
                end
            end
            if (exec_stb) begin
                if (prev_stb) stb_double = 1'b1;
                busy = 1'b1;
                cnt = lat;
                if (n_exec < 64) exec_log[n_exec] = int'(td_ptr);
                n_exec = n_exec + 1;
            end
            prev_stb = exec_stb;
        end
    end

    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            if (sof_en) begin
                c = c + 1;
                sof_tick = (c % 40 == 0);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_wr = 1'b0; sof_en = 1'b0; sof_tick = 1'b0; lat = 3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg(input bit run, input bit dbg);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_run = run; cfg_dbg = dbg;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_sof();
        @(negedge clk); sof_tick = 1'b1;
        @(negedge clk); sof_tick = 1'b0;
    endtask

    task automatic wait_exec(input int target);
        for (int i = 0; i < 3000 && n_exec < target; i++) @(negedge clk);
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(halted == 1'b1, "R1", "halted after reset", halted, 1);
        chk(run_bit == 1'b0 && dbg_bit == 1'b0, "R1", "run/dbg after reset", {run_bit, dbg_bit}, 0);
        chk(frame_num == 0, "R1", "frame after reset", frame_num, 0);
        repeat (5) @(negedge clk);
        chk(!fetch_req && !exec_stb, "R1", "idle while halted", {fetch_req, exec_stb}, 0);
    endtask

    task automatic t_normal();
        int base;
        do_reset();
        base = n_exec;
        frame_index = 10'd2; sof_en = 1'b1;
        cfg(1'b1, 1'b0);
        chk(halted == 1'b0, "R2", "halted drops on start", halted, 0);
        wait_exec(base + 4);
        chk(exec_log[base] == 1 && exec_log[base+1] == 5, "R5", "frame walk skips inactive", exec_log[base+1], 5);
        chk(exec_log[base+2] == 1 && exec_log[base+3] == 5, "R5", "next frame restarts at head", exec_log[base+2], 1);
        chk(frame_num > 2, "R5", "frame number advanced", frame_num, 3);
        lat = 6;
        for (int i = 0; i < 500 && !exec_stb; i++) @(negedge clk);
        cfg_wr = 1'b1; cfg_run = 1'b0; cfg_dbg = 1'b0;
        @(negedge clk); cfg_wr = 1'b0;
        @(negedge clk);
        chk(halted == 1'b0, "R10", "no halt while executing", halted, 0);
        chk(fetch_req == 1'b0, "R6", "no fetch before done", fetch_req, 0);
        repeat (10) @(negedge clk);
        chk(halted == 1'b1, "R10", "halt after done", halted, 1);
        chk(frame_num == 0, "R10", "frame counter cleared", frame_num, 0);
        // restart begins at frame_index
        sof_en = 1'b0; sof_tick = 1'b0; lat = 3;
        frame_index = 10'd5;
        cfg(1'b1, 1'b0);
        @(negedge clk);
        chk(fetch_req && td_ptr == 8, "R4", "first fetch at frame head", td_ptr, 8);
        chk(frame_num == 5, "R4", "frame loaded from index", frame_num, 5);
        cfg(1'b0, 1'b0);
        wait_halt();
    endtask

    task automatic t_empty();
        int base;
        do_reset();
        frame_index = 10'd6;
        base = n_exec;
        cfg(1'b1, 1'b0);
        repeat (30) @(negedge clk);
        chk(n_exec == base, "R5", "empty frame executes nothing", n_exec - base, 0);
        chk(!halted && !fetch_req, "R5", "empty frame waits for SOF", {halted, fetch_req}, 0);
        pulse_sof();
        wait_exec(base + 1);
        chk(n_exec == base + 1 && exec_log[base] == 1, "R5", "next frame runs", exec_log[base], 1);
        chk(frame_num == 7, "R5", "frame increments on SOF", frame_num, 7);
        cfg(1'b0, 1'b0);
        wait_halt();
    endtask

    task automatic t_debug();
        int base;
        do_reset();
        frame_index = 10'd0;
        base = n_exec;
        cfg(1'b1, 1'b1);
        for (int i = 0; i < 50 && !exec_stb; i++) @(negedge clk);
        chk(exec_stb && td_ptr == 1, "R7", "step executes first active", td_ptr, 1);
        chk(run_bit == 1'b0, "R7", "run cleared by hardware", run_bit, 0);
        chk(halted == 1'b0, "R8", "not halted during exec", halted, 0);
        wait_halt();
        chk(halted && td_ptr == 4, "R8", "halt with pointer at link", td_ptr, 4);
        // second step: skip 4, execute 5 which ends the frame
        cfg(1'b1, 1'b1);
        wait_exec(base + 2);
        chk(exec_log[base+1] == 5, "R8", "resume skips inactive", exec_log[base+1], 5);
        repeat (12) @(negedge clk);
        chk(halted == 1'b0 && run_bit == 1'b0, "R9", "waits for SOF before halt", halted, 0);
        pulse_sof();
        repeat (6) @(negedge clk);
        chk(halted == 1'b1, "R9", "halt after prefetch", halted, 1);
        chk(frame_num == 1 && td_ptr == 1, "R9", "pointer at new frame head", td_ptr, 1);
        chk(n_exec == base + 2, "R9", "prefetched TD not executed", n_exec - base, 2);
        cfg(1'b1, 1'b1);
        wait_exec(base + 3);
        chk(exec_log[base+2] == 1, "R8", "resume at prefetched TD", exec_log[base+2], 1);
        wait_halt();
    endtask

    task automatic t_collide();
        do_reset();
        frame_index = 10'd0;
        cfg(1'b1, 1'b1);
        wait_halt();
        // resume at 4 (inactive), collide on the fetch of 5
        @(negedge clk);
        cfg_wr = 1'b1; cfg_run = 1'b1; cfg_dbg = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        chk(run_bit == 1'b1, "R3", "software write wins", run_bit, 1);
        chk(exec_stb && td_ptr == 5, "R3", "found TD still executes", td_ptr, 5);
        cfg(1'b0, 1'b1);
        wait_halt();
    endtask

    task automatic t_exit_dbg();
        int base;
        bit saw_halt;
        do_reset();
        frame_index = 10'd0;
        cfg(1'b1, 1'b1);
        wait_halt();
        base = n_exec;
        saw_halt = 1'b0;
        sof_en = 1'b1;
        cfg(1'b1, 1'b0);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (halted) saw_halt = 1'b1;
        end
        chk(!saw_halt && run_bit, "R11", "continuous after debug exit", saw_halt, 0);
        chk(n_exec - base >= 4, "R11", "several TDs executed", n_exec - base, 4);
        sof_en = 1'b0; sof_tick = 1'b0;
        cfg(1'b0, 1'b0);
        wait_halt();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal();
        t_empty();
        t_debug();
        t_collide();
        t_exit_dbg();
        chk(stb_double == 1'b0, "R6", "strobe single cycle", stb_double, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule